// File: doc/BRIEF.md
# Rotating Priority Interrupt Resolver

This block is the priority core of an eight-input interrupt controller. The request and mask registers live outside it and arrive as inputs. It holds the in-service register, a movable lowest-priority pointer and the rotate flag from the most recent command.

Every cycle it works out which pending, unmasked level has the highest priority. The search starts one level above the lowest-priority pointer and wraps. It stops early when it reaches a level that is already in service, unless a special mode removes that blocking.

It carries out end-of-interrupt and rotation commands. It records acknowledgements, with or without automatic end of interrupt. It drives an interrupt-raised line that stays up until the acknowledgement arrives.

A surrounding controller feeds it the programmed mode bits and decoded command strobes. It uses `pend_level_o` as the vector offset at acknowledge time. When nothing is eligible, that output reads level 7, which is the spurious level.

Top module: `irq_prio_resolver`

## Requirements
- R1: Levels are searched in priority order starting at (lowest-priority pointer + 1) mod 8 and wrapping through all eight levels. The first level with its request bit set and its mask bit clear wins: `pend_valid_o`=1 and `pend_level_o` is that level. The result is combinational in the current inputs and registered state.
- R2: The search ends with no winner as soon as it reaches a level whose in-service bit blocks it. When no level wins, `pend_valid_o`=0 and `pend_level_o`=7 (spurious).
- R3: With `sfnm_i`=1, the in-service bit of level 2 never blocks the search. With `smm_i`=1, no in-service bit blocks the search.
- R4: A command with `cmd_eoi_i`=1 and `cmd_specific_i`=1 clears the in-service bit of `cmd_level_i`. With `cmd_eoi_i`=1 and `cmd_specific_i`=0, the command clears the highest-priority set in-service bit. In that non-specific case, while `smm_i`=1, in-service bits whose mask bit is set are skipped. If no bit qualifies, nothing changes.
- R5: Every command stores `cmd_rotate_i` as the rotate flag. When an end-of-interrupt command with `cmd_rotate_i`=1 clears a level, that level becomes the lowest-priority pointer. This holds for any specific command, and for a non-specific one that found a bit. A command with `cmd_eoi_i`=0, `cmd_specific_i`=1 and `cmd_rotate_i`=1 loads the pointer from `cmd_level_i`.
- R6: On `ack_i` with `aeoi_i`=0, the in-service bit of `ack_level_i` is set. With `aeoi_i`=1, the in-service register is untouched, and the pointer becomes `ack_level_i` if the stored rotate flag is set.
- R7: During an `ack_i` cycle, `req_clear_o` has only bit `ack_level_i` set, and only if `line_i` for that level is low. Outside acknowledge cycles it is zero.
- R8: `irq_o` rises on the clock after `pend_valid_o` is seen while it is low. It stays high until `ack_i`. It is low on the clock after an `ack_i`.
- R9: Reset clears the in-service register, the rotate flag and `irq_o`, and sets the pointer to 7.
- R10: A command presented in the same cycle as `ack_i` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_i | input | 8 | Request register |
| mask_i | input | 8 | Mask register, 1 disables a level |
| line_i | input | 8 | Present state of each request input |
| sfnm_i | input | 1 | Cascade level 2 in service does not block |
| smm_i | input | 1 | In-service bits do not block; non-specific EOI skips masked bits |
| aeoi_i | input | 1 | Automatic end of interrupt on acknowledge |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_eoi_i | input | 1 | Command is an end of interrupt |
| cmd_specific_i | input | 1 | Command uses `cmd_level_i` |
| cmd_rotate_i | input | 1 | Rotate bit of the command |
| cmd_level_i | input | 3 | Level operand of the command |
| ack_i | input | 1 | Interrupt acknowledge strobe |
| ack_level_i | input | 3 | Level being acknowledged |
| pend_valid_o | output | 1 | An eligible level exists |
| pend_level_o | output | 3 | Winning level, 7 when none |
| irq_o | output | 1 | Interrupt raised |
| isr_o | output | 8 | In-service register |
| lowprio_o | output | 3 | Lowest-priority pointer |
| req_clear_o | output | 8 | Request bits to clear after acknowledge |

## Verification
`pend_valid_o`, `pend_level_o` and `req_clear_o` are combinational. They are due in the same cycle as the inputs that cause them. `isr_o`, `lowprio_o` and `irq_o` change on the first clock edge after a command or acknowledge is presented.

The bench drives inputs just after a falling edge and compares every output one time unit later against a behavioural model of the current state. It then advances that model at the rising edge, so each registered result is checked in the cycle after its cause. Sequences aimed at rotation, the special modes, the spurious level and a command colliding with an acknowledge are followed by a long pseudo-random run.

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
  parameter int N_LVL    = 8,
  parameter int CASC_LVL = 2
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [N_LVL-1:0]         req_i,
  input  logic [N_LVL-1:0]         mask_i,
  input  logic [N_LVL-1:0]         line_i,
  input  logic                     sfnm_i,
  input  logic                     smm_i,
  input  logic                     aeoi_i,
  input  logic                     cmd_valid_i,
  input  logic                     cmd_eoi_i,
  input  logic                     cmd_specific_i,
  input  logic                     cmd_rotate_i,
  input  logic [$clog2(N_LVL)-1:0] cmd_level_i,
  input  logic                     ack_i,
  input  logic [$clog2(N_LVL)-1:0] ack_level_i,
  output logic                     pend_valid_o,
  output logic [$clog2(N_LVL)-1:0] pend_level_o,
  output logic                     irq_o,
  output logic [N_LVL-1:0]         isr_o,
  output logic [$clog2(N_LVL)-1:0] lowprio_o,
  output logic [N_LVL-1:0]         req_clear_o
);
  localparam int LW = $clog2(N_LVL);
  localparam logic [LW-1:0] TOP_LVL = LW'(N_LVL - 1);
  localparam logic [N_LVL-1:0] ONE = N_LVL'(1);
  localparam logic [N_LVL-1:0] CASC_BIT = ONE << CASC_LVL;

  logic [N_LVL-1:0] isr_q;
  logic [LW-1:0]    low_q;
  logic             rot_q;
  logic             irq_q;

  logic [N_LVL-1:0] blk;
  logic [N_LVL-1:0] eoi_cand;
  logic             win_v, eoi_v;
  logic [LW-1:0]    win_l, eoi_l;

  assign blk      = smm_i ? '0 : (isr_q & ~(sfnm_i ? CASC_BIT : '0));
  assign eoi_cand = isr_q & ~(smm_i ? mask_i : '0);

  always_comb begin
    logic stop;
    logic [LW-1:0] lvl;
    stop  = 1'b0;
    lvl   = '0;
    win_v = 1'b0;
    win_l = TOP_LVL;
    for (int i = 0; i < N_LVL; i++) begin
      lvl = LW'((int'(low_q) + 1 + i) % N_LVL);
      if (!stop) begin
        if (blk[lvl]) begin
          stop = 1'b1;
        end else if (req_i[lvl] && !mask_i[lvl]) begin
          win_v = 1'b1;
          win_l = lvl;
          stop  = 1'b1;
        end
      end
    end
  end

  always_comb begin
    logic [LW-1:0] lvl;
    lvl   = '0;
    eoi_v = 1'b0;
    eoi_l = '0;
    for (int i = 0; i < N_LVL; i++) begin
      lvl = LW'((int'(low_q) + 1 + i) % N_LVL);
      if (!eoi_v && eoi_cand[lvl]) begin
        eoi_v = 1'b1;
        eoi_l = lvl;
      end
    end
  end

  logic          tgt_v;
  logic [LW-1:0] tgt_l;
  assign tgt_v = cmd_specific_i | eoi_v;
  assign tgt_l = cmd_specific_i ? cmd_level_i : eoi_l;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      isr_q <= '0;
      low_q <= TOP_LVL;
      rot_q <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= ack_i ? 1'b0 : (irq_q | win_v);
      if (ack_i) begin
        if (!aeoi_i)    isr_q[ack_level_i] <= 1'b1;
        else if (rot_q) low_q <= ack_level_i;
      end else if (cmd_valid_i) begin
        rot_q <= cmd_rotate_i;
        if (cmd_eoi_i) begin
          if (tgt_v) begin
            isr_q[tgt_l] <= 1'b0;
            if (cmd_rotate_i) low_q <= tgt_l;
          end
        end else if (cmd_specific_i && cmd_rotate_i) begin
          low_q <= cmd_level_i;
        end
      end
    end
  end

  assign pend_valid_o = win_v;
  assign pend_level_o = win_l;
  assign irq_o        = irq_q;
  assign isr_o        = isr_q;
  assign lowprio_o    = low_q;
  assign req_clear_o  = ack_i ? ((ONE << ack_level_i) & ~line_i) : '0;
endmodule

module irq_prio_resolver_chk #(
  parameter int N_LVL = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [N_LVL-1:0]         req_i,
  input logic [N_LVL-1:0]         mask_i,
  input logic                     aeoi_i,
  input logic                     cmd_valid_i,
  input logic                     cmd_eoi_i,
  input logic                     cmd_specific_i,
  input logic [$clog2(N_LVL)-1:0] cmd_level_i,
  input logic                     ack_i,
  input logic [$clog2(N_LVL)-1:0] ack_level_i,
  input logic                     pend_valid_o,
  input logic [$clog2(N_LVL)-1:0] pend_level_o,
  input logic                     irq_o,
  input logic [N_LVL-1:0]         isr_o
);
  AST_WINNER_ELIGIBLE: assert property (@(posedge clk) disable iff (!rst_n) pend_valid_o |-> (req_i[pend_level_o] && !mask_i[pend_level_o])); // R1
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n) (!irq_o && pend_valid_o && !ack_i) |=> irq_o); // R8
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (irq_o && !ack_i) |=> irq_o); // R8
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n) ack_i |=> !irq_o); // R8
  AST_ACK_SETS_ISR: assert property (@(posedge clk) disable iff (!rst_n) (ack_i && !aeoi_i) |=> isr_o[$past(ack_level_i)]); // R6
  AST_SPECIFIC_EOI: assert property (@(posedge clk) disable iff (!rst_n) (cmd_valid_i && !ack_i && cmd_eoi_i && cmd_specific_i) |=> !isr_o[$past(cmd_level_i)]); // R4
endmodule

bind irq_prio_resolver irq_prio_resolver_chk #(.N_LVL(N_LVL)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .mask_i(mask_i), .aeoi_i(aeoi_i),
  .cmd_valid_i(cmd_valid_i), .cmd_eoi_i(cmd_eoi_i), .cmd_specific_i(cmd_specific_i),
  .cmd_level_i(cmd_level_i), .ack_i(ack_i), .ack_level_i(ack_level_i),
  .pend_valid_o(pend_valid_o), .pend_level_o(pend_level_o), .irq_o(irq_o), .isr_o(isr_o)
);

// File: tb/irq_prio_resolver_bench.sv
`timescale 1ns/1ps
module irq_prio_resolver_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0] req = '0, mask = '0, line = '0;
  logic sfnm = 0, smm = 0, aeoi = 0;
  logic cv = 0, ce = 0, cs = 0, cr = 0, ack = 0;
  logic [2:0] cl = '0, al = '0;
  logic pv, irq;
  logic [2:0] pl, low;
  logic [7:0] isr, rclr;

  always #2 clk = ~clk;

  irq_prio_resolver u_irq_prio_resolver (
    .clk(clk), .rst_n(rst_n), .req_i(req), .mask_i(mask), .line_i(line),
    .sfnm_i(sfnm), .smm_i(smm), .aeoi_i(aeoi), .cmd_valid_i(cv), .cmd_eoi_i(ce),
    .cmd_specific_i(cs), .cmd_rotate_i(cr), .cmd_level_i(cl), .ack_i(ack),
    .ack_level_i(al), .pend_valid_o(pv), .pend_level_o(pl), .irq_o(irq),
    .isr_o(isr), .lowprio_o(low), .req_clear_o(rclr)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  bit [7:0] m_isr;
  int m_low;
  bit m_rot, m_irq;
  bit [31:0] seed = 32'h1badb002;

  function automatic bit [31:0] rnd();
    seed ^= seed << 13; seed ^= seed >> 17; seed ^= seed << 5;
    return seed;
  endfunction

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s at %0t: got %0h expected %0h", tag, $time, got, exp);
    end
  endtask

  // R1 R2 R3 model of the search
  function automatic void m_pend(output bit v, output int lv);
    bit [7:0] b;
    b = smm ? 8'h00 : (m_isr & ~(sfnm ? 8'h04 : 8'h00));
    v = 0; lv = 7;
    for (int i = 0; i < 8; i++) begin
      int k;
      k = (m_low + 1 + i) % 8;
      if (b[k]) return;
      if (req[k] && !mask[k]) begin v = 1; lv = k; return; end
    end
  endfunction

  task automatic compare();
    bit v; int lv; bit [7:0] ec;
    m_pend(v, lv);
    ec = ack ? (8'(1 << al) & ~line) : 8'h00;
    chk("R1 R3 pend_valid", pv, v);
    chk("R2 pend_level", pl, lv);
    chk("R8 irq", irq, m_irq);
    chk("R4 R6 isr", isr, m_isr);
    chk("R5 lowprio", low, m_low);
    chk("R7 req_clear", rclr, ec);
  endtask

  task automatic cyc();
    bit v; int lv;
    bit [7:0] n_isr; int n_low; bit n_rot, n_irq;
    #1 compare();
    m_pend(v, lv);
    n_isr = m_isr; n_low = m_low; n_rot = m_rot;
    n_irq = ack ? 1'b0 : (m_irq | v);
    if (ack) begin
      if (!aeoi) n_isr[al] = 1;
      else if (m_rot) n_low = al;
    end else if (cv) begin // R10: command only without ack
      n_rot = cr;
      if (ce) begin
        int t; t = -1;
        if (cs) t = cl;
        else for (int i = 0; i < 8; i++) begin
          int k; k = (m_low + 1 + i) % 8;
          if (t < 0 && m_isr[k] && !(smm && mask[k])) t = k;
        end
        if (t >= 0) begin n_isr[t] = 0; if (cr) n_low = t; end
      end else if (cs && cr) n_low = cl;
    end
    @(posedge clk);
    m_isr = n_isr; m_low = n_low; m_rot = n_rot; m_irq = n_irq;
    @(negedge clk);
  endtask

  task automatic idle();
    cv = 0; ack = 0;
  endtask

  task automatic cmd(bit e, bit s, bit r, int l);
    cv = 1; ce = e; cs = s; cr = r; cl = 3'(l); cyc(); cv = 0;
  endtask

  task automatic do_ack(int l);
    ack = 1; al = 3'(l); cyc(); ack = 0;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    m_isr = 0; m_low = 7; m_rot = 0; m_irq = 0;
    #1;
    chk("R9 reset isr", isr, 0);
    chk("R9 reset lowprio", low, 7);
    chk("R9 reset irq", irq, 0);
    chk("R2 spurious level", pl, 7);
    @(negedge clk);

    req = 8'h09; cyc();
    chk("R1 default order picks 0", pl, 0);
    do_ack(0);
    chk("R6 ack sets isr", isr, 8'h01);
    req = 8'h08; cyc();
    chk("R2 blocked by level 0", pv, 0);
    cmd(1, 0, 1, 0);
    chk("R5 rotate eoi lowprio", low, 0);
    req = 8'h8A; mask = 8'h02; cyc();
    chk("R1 rotated masked", pl, 3);
    cmd(0, 1, 1, 4); req = 8'h09; cyc();
    chk("R5 set priority picks 0", pl, 0);
    do_ack(0); do_ack(0);
    sfnm = 1; do_ack(2); req = 8'h08; cyc();
    chk("R3 sfnm not blocked", pv, 0);
    smm = 1; cyc();
    chk("R3 smm unblocks", pv, 1);
    mask = 8'h01; cmd(1, 0, 0, 0); smm = 0; sfnm = 0;
    ack = 1; al = 3'd5; line = 8'h00; cv = 1; ce = 1; cs = 1; cr = 1; cl = 3'd2;
    #1 chk("R7 req_clear at ack", rclr, 8'h20);
    #0 cyc(); idle();
    chk("R10 command ignored", low, 4);
    aeoi = 1; m_rot = m_rot; cmd(0, 0, 1, 0); do_ack(6);
    chk("R6 aeoi rotate", low, 6);
    aeoi = 0; mask = 0; req = 0;
    for (int c = 0; c < 6000; c++) begin
      bit [31:0] r;
      r = rnd();
      req = 8'(rnd()) & 8'(rnd() >> 3);
      mask = 8'(rnd()) & 8'(rnd() >> 5) & 8'(rnd() >> 9);
      line = 8'(rnd());
      if (r[7:0] == 0) sfnm = ~sfnm;
      if (r[15:8] < 8) smm = ~smm;
      if (r[23:16] < 4) aeoi = ~aeoi;
      cv = (r[27:24] < 3); ce = r[28]; cs = r[29]; cr = r[30]; cl = 3'(rnd());
      ack = m_irq && (r[31] || rnd() % 3 == 0);
      al = (rnd() % 4 == 0) ? 3'(rnd()) : pl;
      cyc();
    end
    idle();
    cyc();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule